// File: doc/BRIEF.md
# System Handler Status and Priority Register Block

This block is the register face of the fault and system handlers in an interrupt controller. It holds one priority byte per handler in a packed window and reports the active and pending state of each handler. The pending and active state comes from the arbiter, while the enables for the three configurable faults are stored here. Software reaches it through a simple register port that carries an address, an access size code and a 32-bit data word. Read data and the error flag appear one cycle after the request.

Besides the handler registers, the block keeps a vector-table base register whose low bits cannot be written. It also has a keyed application-control register. A write to that register has an effect only when its upper half carries the key, and a valid keyed write is passed on as a one-cycle command strobe. A fault-status range reads as zero, and a small identification window returns parameter bytes. Whenever a priority byte is written, the arbiter is told through a one-cycle update strobe so that it can re-evaluate arbitration.

Top module: `shr_regblk`

## Requirements
- R1: After reset, rdata_o, err_o, fault_en_o, prio_o, prio_upd_o, vtor_o, app_req_o and app_cmd_o are all zero.
- R2: A word read (size code 2) at offset 0xD24 returns, in the cycle after the request, the live handler state. hnd_active_i bits 0..6 (mem-manage, bus, usage, svcall, debug monitor, pendsv, systick) appear at bits 0, 1, 3, 7, 8, 10 and 11. hnd_pend_i bits 0..3 (usage, mem-manage, bus, svcall) appear at bits 12..15. fault_en_o bits 0..2 appear at bits 16..18. All other bits are zero.
- R3: A word write at 0xD24 loads fault_en_o from data bits 18:16 in the next cycle. Every other data bit is ignored, and fault_en_o changes on no other access.
- R4: The priority of handler k (0..11) sits at offset 0xD18+k. An access of size code 0, 1 or 2 covers 1, 2 or 4 consecutive bytes from its offset, and byte lane i of the data maps to offset+i. Lanes past 0xD23 are discarded on writes and read as zero.
- R5: Any write that starts inside 0xD18..0xD23 with a valid size pulses prio_upd_o high for exactly one cycle, in the cycle after the request.
- R6: A word read at 0xD0C returns 0x0FA05000. A word write there whose bits 31:16 equal 0x05FA pulses app_req_o for one cycle and sets app_cmd_o to data bits 2:0. Any other write there causes neither.
- R7: A word write at 0xD08 stores the data ANDed with 0xFFFFFF80 into vtor_o. A word read there returns that value.
- R8: A read at 0xFE0+4k (k = 0..7) returns byte k of parameter ID_BYTES (bits 8k+7:8k) in rdata bits 7:0. A read at any unaligned offset in 0xFE0..0xFFF returns zero, and writes in this range have no effect.
- R9: The registers at 0xD24, 0xD08 and 0xD0C read zero and ignore writes for size codes other than 2. The range 0xD28..0xD3F always reads zero and ignores writes.
- R10: An access at an offset outside all ranges above, or an access with size code 3, reads zero and changes no state. It also raises err_o for exactly one cycle, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| wdata_i | input | 32 | Write data, byte lane i at bits 8i+7:8i |
| rdata_o | output | 32 | Read data, updated the cycle after a read |
| err_o | output | 1 | One-cycle flag for a bad access |
| hnd_active_i | input | 7 | Active state of the handlers from the arbiter |
| hnd_pend_i | input | 4 | Pending state of the handlers from the arbiter |
| fault_en_o | output | 3 | Enables: mem-manage, bus, usage |
| prio_o | output | N_PRIO*8 | Priority bytes, handler k at bits 8k+7:8k |
| prio_upd_o | output | 1 | One-cycle strobe after a priority write |
| vtor_o | output | 32 | Vector-table base |
| app_req_o | output | 1 | One-cycle strobe after a keyed write |
| app_cmd_o | output | 3 | Command bits of the last keyed write |

## Verification
Two things can happen in the same cycle. A status read can arrive in the very cycle that the arbiter's active and pending inputs change. Also, an enable write can be followed at once by a status read whose result must already show the new enables. The bench drives fresh random handler state on every cycle of its random phase and mixes status reads and writes into that traffic, so both collisions occur many times. The reference model samples the inputs at the same edge as the design and applies state in read-before-write order, and every registered output is compared on every cycle.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_STAT,
    RK_VTOR,
    RK_APP,
    RK_FAULT,
    RK_ID
  } reg_kind_e;

  // number of byte lanes an access of a size code covers, 0 for the invalid code
  function automatic logic [2:0] lane_count(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // assemble the handler status word from its sources
  function automatic logic [31:0] pack_status(logic [6:0] act, logic [3:0] pend,
                                              logic [2:0] en);
    logic [31:0] v;
    v       = '0;
    v[0]    = act[0];
    v[1]    = act[1];
    v[3]    = act[2];
    v[7]    = act[3];
    v[8]    = act[4];
    v[10]   = act[5];
    v[11]   = act[6];
    v[15:12] = pend;
    v[18:16] = en;
    return v;
  endfunction

endpackage

// File: rtl/shr_addr_dec.sv
module shr_addr_dec
  import shr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PRIO_BASE = 'hD18,
  parameter int N_PRIO    = 12
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [1:0]                size_i,
  output reg_kind_e                 kind_o,
  output logic                      word_o,
  output logic [2:0]                nlanes_o,
  output logic [$clog2(N_PRIO)-1:0] base_o,
  output logic [2:0]                id_idx_o,
  output logic                      id_al_o
);
  localparam int IDX_W     = $clog2(N_PRIO);
  localparam int OFF_STAT  = 'hD24;
  localparam int OFF_VTOR  = 'hD08;
  localparam int OFF_APP   = 'hD0C;
  localparam int FLT_LO    = 'hD28;
  localparam int FLT_HI    = 'hD3F;
  localparam int ID_LO     = 'hFE0;
  localparam int ID_HI     = 'hFFF;

  int off;

  always_comb begin
    off    = int'(addr_i);
    kind_o = RK_NONE;
    base_o = '0;
    if (size_i == 2'd3) begin
      kind_o = RK_NONE;
    end else if (off >= PRIO_BASE && off < PRIO_BASE + N_PRIO) begin
      kind_o = RK_PRIO;
      base_o = IDX_W'(off - PRIO_BASE);
    end else if (off == OFF_STAT) begin
      kind_o = RK_STAT;
    end else if (off == OFF_VTOR) begin
      kind_o = RK_VTOR;
    end else if (off == OFF_APP) begin
      kind_o = RK_APP;
    end else if (off >= FLT_LO && off <= FLT_HI) begin
      kind_o = RK_FAULT;
    end else if (off >= ID_LO && off <= ID_HI) begin
      kind_o = RK_ID;
    end
  end

  assign word_o   = (size_i == 2'd2);
  assign nlanes_o = lane_count(size_i);
  assign id_idx_o = addr_i[4:2];
  assign id_al_o  = (addr_i[1:0] == 2'b00);

endmodule

// File: rtl/shr_prio_bank.sv
module shr_prio_bank #(
  parameter int N_PRIO = 12,
  parameter int IDX_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      base_i,
  input  logic [2:0]            nlanes_i,
  input  logic [31:0]           wdata_i,
  output logic [N_PRIO*8-1:0]   prio_o,
  output logic [31:0]           rd_o
);

  for (genvar j = 0; j < N_PRIO; j++) begin : g_slot
    int         rel;
    logic       hit;
    logic [1:0] lane;
    logic [7:0] q;

    always_comb begin
      rel  = j - int'(base_i);
      hit  = wr_i && (rel >= 0) && (rel < int'(nlanes_i));
      lane = rel[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata_i[8*lane +: 8];
    end

    assign prio_o[8*j +: 8] = q;
  end

  int idx;
  always_comb begin
    rd_o = '0;
    idx  = 0;
    for (int l = 0; l < 4; l++) begin
      idx = int'(base_i) + l;
      if (l < int'(nlanes_i) && idx < N_PRIO) rd_o[8*l +: 8] = prio_o[8*idx +: 8];
    end
  end

endmodule

// File: rtl/shr_ctrl_regs.sv
module shr_ctrl_regs #(
  parameter logic [15:0] APP_KEY   = 16'h05FA,
  parameter logic [31:0] VTOR_MASK = 32'hFFFFFF80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat_i,
  input  logic        wr_vtor_i,
  input  logic        wr_app_i,
  input  logic [31:0] wdata_i,
  output logic [2:0]  fault_en_o,
  output logic [31:0] vtor_o,
  output logic        app_req_o,
  output logic [2:0]  app_cmd_o
);

  function automatic logic key_ok(logic [31:0] d);
    return d[31:16] == APP_KEY;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_en_o <= '0;
      vtor_o     <= '0;
      app_req_o  <= 1'b0;
      app_cmd_o  <= '0;
    end else begin
      app_req_o <= 1'b0;
      if (wr_stat_i) fault_en_o <= wdata_i[18:16];
      if (wr_vtor_i) vtor_o     <= wdata_i & VTOR_MASK;
      if (wr_app_i && key_ok(wdata_i)) begin
        app_req_o <= 1'b1;
        app_cmd_o <= wdata_i[2:0];
      end
    end
  end

endmodule

// File: rtl/shr_regblk.sv
module shr_regblk
  import shr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          N_PRIO    = 12,
  parameter int          PRIO_BASE = 'hD18,
  parameter logic [15:0] APP_KEY   = 16'h05FA,
  parameter logic [31:0] APP_RD    = 32'h0FA05000,
  parameter logic [31:0] VTOR_MASK = 32'hFFFFFF80,
  parameter logic [63:0] ID_BYTES  = 64'hC3A507114D006219
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                err_o,
  input  logic [6:0]          hnd_active_i,
  input  logic [3:0]          hnd_pend_i,
  output logic [2:0]          fault_en_o,
  output logic [N_PRIO*8-1:0] prio_o,
  output logic                prio_upd_o,
  output logic [31:0]         vtor_o,
  output logic                app_req_o,
  output logic [2:0]          app_cmd_o
);
  localparam int IDX_W = $clog2(N_PRIO);

  reg_kind_e        kind;
  logic             word;
  logic [2:0]       nlanes;
  logic [IDX_W-1:0] base;
  logic [2:0]       id_idx;
  logic             id_al;

  shr_addr_dec #(.ADDR_W(ADDR_W), .PRIO_BASE(PRIO_BASE), .N_PRIO(N_PRIO)) u_dec (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .kind_o   (kind),
    .word_o   (word),
    .nlanes_o (nlanes),
    .base_o   (base),
    .id_idx_o (id_idx),
    .id_al_o  (id_al)
  );

  // named access events, shared with the checker
  logic rd_ev, wr_prio_ev, wr_stat_ev, wr_vtor_ev, wr_app_ev, bad_ev;
  assign rd_ev      = req_i && !we_i;
  assign wr_prio_ev = req_i && we_i && (kind == RK_PRIO);
  assign wr_stat_ev = req_i && we_i && (kind == RK_STAT) && word;
  assign wr_vtor_ev = req_i && we_i && (kind == RK_VTOR) && word;
  assign wr_app_ev  = req_i && we_i && (kind == RK_APP) && word;
  assign bad_ev     = req_i && (kind == RK_NONE);

  logic [31:0] prio_rd;

  shr_prio_bank #(.N_PRIO(N_PRIO), .IDX_W(IDX_W)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_prio_ev),
    .base_i   (base),
    .nlanes_i (nlanes),
    .wdata_i  (wdata_i),
    .prio_o   (prio_o),
    .rd_o     (prio_rd)
  );

  shr_ctrl_regs #(.APP_KEY(APP_KEY), .VTOR_MASK(VTOR_MASK)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stat_i  (wr_stat_ev),
    .wr_vtor_i  (wr_vtor_ev),
    .wr_app_i   (wr_app_ev),
    .wdata_i    (wdata_i),
    .fault_en_o (fault_en_o),
    .vtor_o     (vtor_o),
    .app_req_o  (app_req_o),
    .app_cmd_o  (app_cmd_o)
  );

  logic [31:0] rd_next;
  always_comb begin
    case (kind)
      RK_PRIO: rd_next = prio_rd;
      RK_STAT: rd_next = word ? pack_status(hnd_active_i, hnd_pend_i, fault_en_o) : '0;
      RK_VTOR: rd_next = word ? vtor_o : '0;
      RK_APP:  rd_next = word ? APP_RD : '0;
      RK_ID:   rd_next = id_al ? {24'd0, ID_BYTES[8*id_idx +: 8]} : '0;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o    <= '0;
      err_o      <= 1'b0;
      prio_upd_o <= 1'b0;
    end else begin
      if (rd_ev) rdata_o <= rd_next;
      err_o      <= bad_ev;
      prio_upd_o <= wr_prio_ev;
    end
  end

endmodule

// File: rtl/shr_regblk_chk.sv
module shr_regblk_chk #(
  parameter int          N_PRIO    = 12,
  parameter logic [15:0] APP_KEY   = 16'h05FA,
  parameter logic [31:0] VTOR_MASK = 32'hFFFFFF80
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_i,
  input logic                we_i,
  input logic [31:0]         wdata_i,
  input logic                err_o,
  input logic [2:0]          fault_en_o,
  input logic [N_PRIO*8-1:0] prio_o,
  input logic                prio_upd_o,
  input logic [31:0]         vtor_o,
  input logic                app_req_o,
  input logic                wr_prio_ev,
  input logic                wr_stat_ev,
  input logic                bad_ev
);

  // R5
  prio_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prio_ev |=> prio_upd_o);

  // R5
  prio_upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_upd_o |-> $past(wr_prio_ev));

  // R4
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_prio_ev) |-> $stable(prio_o));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stat_ev) |-> $stable(fault_en_o));

  // R6
  app_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_req_o |-> $past(req_i && we_i && (wdata_i[31:16] == APP_KEY)));

  // R7
  vtor_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vtor_o & ~VTOR_MASK) == 32'd0);

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(bad_ev));

  // R10
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> err_o);

endmodule

bind shr_regblk shr_regblk_chk #(
  .N_PRIO(N_PRIO), .APP_KEY(APP_KEY), .VTOR_MASK(VTOR_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .err_o      (err_o),
  .fault_en_o (fault_en_o),
  .prio_o     (prio_o),
  .prio_upd_o (prio_upd_o),
  .vtor_o     (vtor_o),
  .app_req_o  (app_req_o),
  .wr_prio_ev (wr_prio_ev),
  .wr_stat_ev (wr_stat_ev),
  .bad_ev     (bad_ev)
);

// File: tb/sim_shr_regblk.sv
module sim_shr_regblk;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ID_EXP = 64'hC3A507114D006219;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic [6:0] act = '0;
  logic [3:0] pend = '0;

  logic [31:0] rdata, vtor;
  logic err, prio_upd, app_req;
  logic [2:0] fault_en, app_cmd;
  logic [95:0] prio;

  always #(CLK_PERIOD/2) clk = ~clk;

  shr_regblk u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .hnd_active_i(act), .hnd_pend_i(pend),
    .fault_en_o(fault_en), .prio_o(prio), .prio_upd_o(prio_upd), .vtor_o(vtor),
    .app_req_o(app_req), .app_cmd_o(app_cmd)
  );

  // ---------------- reference model ----------------
  int prio_m[12];
  logic [2:0] en_m;
  logic [31:0] vtor_m, exp_rdata;
  logic exp_err, exp_pu, exp_ar, exp_rst;
  logic [2:0] exp_ac;
  string exp_tag = "R1";
  int vectors = 0, miscompares = 0;

  function automatic int nlan(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
  endfunction

  function automatic bit in_win(int off);
    return off >= 'hD18 && off <= 'hD23;
  endfunction

  function automatic bit mapped(int off, int sz);
    if (sz == 3) return 0;
    return in_win(off) || off == 'hD24 || off == 'hD08 || off == 'hD0C ||
           (off >= 'hD28 && off <= 'hD3F) || (off >= 'hFE0 && off <= 'hFFF);
  endfunction

  function automatic string tag_of(int off, int sz);
    if (!mapped(off, sz)) return "R10";
    if (in_win(off)) return "R4";
    if (off >= 'hFE0) return "R8";
    if (sz != 2 || off >= 'hD28) return "R9";
    if (off == 'hD24) return "R2";
    if (off == 'hD08) return "R7";
    return "R6";
  endfunction

  function automatic logic [31:0] m_read(int off, int sz, logic [6:0] a, logic [3:0] p);
    int apos[7] = '{0, 1, 3, 7, 8, 10, 11};
    logic [31:0] r = '0;
    if (!mapped(off, sz)) return 0;
    if (in_win(off)) begin
      for (int l = 0; l < nlan(sz); l++)
        if (off + l <= 'hD23) r[8*l +: 8] = 8'(prio_m[off + l - 'hD18]);
    end else if (off >= 'hFE0) begin
      if (off % 4 == 0) r[7:0] = ID_EXP[8*((off - 'hFE0) / 4) +: 8];
    end else if (sz == 2 && off == 'hD24) begin
      for (int i = 0; i < 7; i++) r[apos[i]] = a[i];
      for (int i = 0; i < 4; i++) r[12 + i] = p[i];
      for (int i = 0; i < 3; i++) r[16 + i] = en_m[i];
    end else if (sz == 2 && off == 'hD08) r = vtor_m;
    else if (sz == 2 && off == 'hD0C) r = 32'h0FA05000;
    return r;
  endfunction

  always @(posedge clk) begin
    int off, sz;
    if (!rst_n) begin
      foreach (prio_m[i]) prio_m[i] = 0;
      en_m = 0; vtor_m = 0; exp_rdata = 0; exp_err = 0; exp_pu = 0;
      exp_ar = 0; exp_ac = 0; exp_rst = 1;
    end else begin
      exp_rst = 0; exp_err = 0; exp_pu = 0; exp_ar = 0;
      off = int'(addr); sz = int'(size);
      if (req) begin
        if (!mapped(off, sz)) exp_err = 1;
        if (!we) begin
          exp_rdata = m_read(off, sz, act, pend);
          exp_tag = tag_of(off, sz);
        end else if (mapped(off, sz)) begin
          if (in_win(off)) begin
            exp_pu = 1;
            for (int l = 0; l < nlan(sz); l++)
              if (off + l <= 'hD23) prio_m[off + l - 'hD18] = int'(wdata[8*l +: 8]);
          end else if (sz == 2 && off == 'hD24) en_m = wdata[18:16];
          else if (sz == 2 && off == 'hD08) vtor_m = wdata & 32'hFFFFFF80;
          else if (sz == 2 && off == 'hD0C && wdata[31:16] == 16'h05FA) begin
            exp_ar = 1; exp_ac = wdata[2:0];
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [95:0] a, logic [95:0] e);
    if (a !== e) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [95:0] pexp;
    foreach (prio_m[i]) pexp[8*i +: 8] = 8'(prio_m[i]);
    vectors++;
    chk(exp_rst ? "R1" : exp_tag, 96'(rdata), 96'(exp_rdata));
    chk(exp_rst ? "R1" : "R10", 96'(err), 96'(exp_err));
    chk(exp_rst ? "R1" : "R3", 96'(fault_en), 96'(en_m));
    chk(exp_rst ? "R1" : "R4", prio, pexp);
    chk(exp_rst ? "R1" : "R5", 96'(prio_upd), 96'(exp_pu));
    chk(exp_rst ? "R1" : "R7", 96'(vtor), 96'(vtor_m));
    chk(exp_rst ? "R1" : "R6", 96'(app_req), 96'(exp_ar));
    chk(exp_rst ? "R1" : "R6", 96'(app_cmd), 96'(exp_ac));
  end

  // ---------------- stimulus ----------------
  task automatic acc(bit w, int off, int sz, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = 12'(off); size = 2'(sz); wdata = d;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); req = 1'b0; we = 1'b0; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pool[16] = '{'hD18, 'hD19, 'hD1B, 'hD20, 'hD22, 'hD23, 'hD24, 'hD24,
                     'hD08, 'hD0C, 'hD2C, 'hFE4, 'hFE6, 'hFFC, 'hD10, 'h000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                                  // R1 checked during reset above
    // R2: status read while handler inputs change in the same cycle
    act = 7'h55; pend = 4'hA;
    acc(0, 'hD24, 2, 0);
    @(negedge clk); act = 7'h2A; pend = 4'h5; req = 1'b0;
    acc(0, 'hD24, 2, 0);
    // R3: only enable bits stored; R9 non-word write ignored
    acc(1, 'hD24, 2, 32'hFFFFFFFF);
    acc(0, 'hD24, 2, 0);
    acc(1, 'hD24, 1, 32'h0);
    acc(0, 'hD24, 2, 0);
    acc(0, 'hD24, 0, 0);
    // R4/R5: priority window at all widths, straddling the end
    acc(1, 'hD18, 0, 32'h11);
    acc(1, 'hD19, 1, 32'h2233);
    acc(1, 'hD1C, 2, 32'h44556677);
    acc(1, 'hD22, 2, 32'h8899AABB);
    acc(1, 'hD23, 0, 32'hCC);
    acc(0, 'hD18, 2, 0);
    acc(0, 'hD1C, 2, 0);
    acc(0, 'hD20, 2, 0);
    acc(0, 'hD22, 1, 0);
    acc(0, 'hD23, 2, 0);
    acc(0, 'hD19, 0, 0);
    // R6: keyed control
    acc(0, 'hD0C, 2, 0);
    acc(0, 'hD0C, 0, 0);
    acc(1, 'hD0C, 2, 32'h05FA0005);
    acc(1, 'hD0C, 2, 32'h12340003);
    acc(1, 'hD0C, 1, 32'h05FA0001);
    // R7: vector base masking
    acc(1, 'hD08, 2, 32'h12345678);
    acc(0, 'hD08, 2, 0);
    acc(1, 'hD08, 1, 32'hFFFF);
    acc(0, 'hD08, 2, 0);
    acc(0, 'hD08, 0, 0);
    // R8: identification bytes
    for (int k = 0; k < 8; k++) acc(0, 'hFE0 + 4*k, k % 3, 0);
    acc(0, 'hFE1, 2, 0);
    acc(0, 'hFE6, 0, 0);
    acc(1, 'hFE0, 2, 32'hFFFFFFFF);
    acc(0, 'hFE0, 2, 0);
    // R9: fault range
    acc(1, 'hD28, 2, 32'hFFFFFFFF);
    acc(0, 'hD28, 2, 0);
    acc(0, 'hD3C, 2, 0);
    // R10: unmapped and invalid size
    acc(0, 'h000, 2, 0);
    acc(0, 'hD10, 2, 0);
    acc(1, 'hD10, 2, 32'hFFFFFFFF);
    acc(0, 'hD18, 3, 0);
    acc(1, 'hD18, 3, 32'hFFFFFFFF);
    acc(0, 'hD18, 2, 0);
    idle(2);
    // mixed traffic with handler state moving every cycle
    for (int n = 0; n < 800; n++) begin
      int off = pool[$urandom_range(15)];
      logic [31:0] d = $urandom;
      if (off == 'hD0C && $urandom_range(1) == 1) d[31:16] = 16'h05FA;
      acc($urandom_range(1) == 1, off, $urandom_range(3), d);
      act = 7'($urandom); pend = 4'($urandom);
      if ($urandom_range(5) == 0) begin @(negedge clk); req = 1'b0; end
    end
    idle(3);
    finish_run();
  end

endmodule